// File: doc/BRIEF.md
# Inverter Gate Interlock and Fault Logic

This block sits between a PWM generator and the gate drivers of a three-phase inverter bridge that also has a brake switch. It takes seven active-low on-commands: an upper and a lower one for each phase, plus one for the brake. It turns them into seven registered gate enables.

On the way through, each phase is guarded in three ways:

- **Cross-conduction interlock.** It stays latched until a clean new command arrives.
- **Per-switch short-circuit cut-off.** It is released pulse by pulse.
- **Current-limit warning.** It re-arms on the next command pulse of the phase.

Short-circuit and current-limit conditions arrive as ready-made digital flags. All inputs pass through two-flop synchronisers.

The block reports two active-low flags. A fault flag covers an interlock or a short-circuit block in any phase. A warning flag covers a current-limit condition in any phase. A command change reaches the gate outputs three clock edges after it is applied: two synchroniser stages and one output register.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While reset is asserted and right after it, all seven gate enables are 0 and both `fault_n` and `warn_n` are 1.
- R2: A command input driven low turns its gate enable to 1, and driven high turns it to 0. The change appears on the third rising clock edge after the input changes.
- R3: When the upper and lower commands of one phase are both low, both gate enables of that phase go to 0 and `fault_n` goes to 0. The other phases keep following their commands.
- R4: An interlock stays latched with the phase's gates off. It is released only by a high-to-low command edge in that phase that occurs after both of the phase's commands have been high since the latch was set. A release of one input, or a new overlap, keeps it latched.
- R5: When the short-circuit flag of a phase switch is 1, only that switch's gate enable goes to 0, and `fault_n` goes to 0.
- R6: A short-circuit block outlasts its flag until the switch's command returns high. At that point `fault_n` returns to 1, and the next low command turns the gate on again.
- R7: The brake gate enable follows the brake command alone. No short-circuit flag of any phase affects it.
- R8: A phase's current-limit flag drives `warn_n` to 0. It stays 0 after the flag clears, and after the command ends, until the next high-to-low edge of either command of that phase.
- R9: `fault_n` and `warn_n` are each 0 if any phase holds the corresponding condition. A condition raised in one phase is reported even when that phase's switches are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_cmd_n | input | NPH | Upper switch on-command per phase, active low |
| dn_cmd_n | input | NPH | Lower switch on-command per phase, active low |
| brk_cmd_n | input | 1 | Brake switch on-command, active low |
| sc_up | input | NPH | Short-circuit flag of each upper switch |
| sc_dn | input | NPH | Short-circuit flag of each lower switch |
| ilim | input | NPH | Current-limit flag per phase |
| gate_up | output | NPH | Upper gate enables |
| gate_dn | output | NPH | Lower gate enables |
| gate_brk | output | 1 | Brake gate enable |
| fault_n | output | 1 | Fault flag, active low |
| warn_n | output | 1 | Current-limit warning flag, active low |

## Verification
The hardest situation to reach is the interlock release. The latch must survive several command moves that look like releases but are not:

- one input going high while the other stays low;
- a fresh overlap;
- both inputs resting high with no new edge.

Only then must it clear on the first proper falling edge. The stimulus walks one phase through that sequence step by step, checking the gates and `fault_n` after each step. Short-circuit blocks and warnings are also held past the removal of their flags, so the pulse-by-pulse release is seen separately from the flag itself.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  // A switch becomes commanded on in this cycle
  function automatic logic turn_on(input logic now_on, input logic was_on);
    return now_on & ~was_on;
  endfunction

  // Both switches of a leg requested at once
  function automatic logic cross_req(input logic up_on, input logic dn_on);
    return up_on & dn_on;
  endfunction

  // Next state of a pulse-held block: set by flag, kept while command stays on
  function automatic logic hold_in_pulse(input logic flag, input logic held, input logic cmd_on);
    return flag | (held & cmd_on);
  endfunction

endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= {W{RST_VAL}};
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/bgc_leg.sv
module bgc_leg
  import bgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_on,
  input  logic dn_on,
  input  logic sc_up,
  input  logic sc_dn,
  input  logic ilim,
  output logic gate_up,
  output logic gate_dn,
  output logic lock,
  output logic blk_up,
  output logic blk_dn,
  output logic warn
);
  logic up_was, dn_was;
  logic arm_up_q, arm_dn_q;
  logic lock_q, blk_up_q, blk_dn_q, warn_q, gup_q, gdn_q;

  // named internal events
  logic new_up, new_dn, new_pulse, overlap, lock_clr, lock_d;
  logic blk_up_d, blk_dn_d, warn_d, arm_up_d, arm_dn_d;

  assign new_up    = turn_on(up_on, up_was);
  assign new_dn    = turn_on(dn_on, dn_was);
  assign new_pulse = new_up | new_dn;
  assign overlap   = cross_req(up_on, dn_on);

  assign lock_clr = lock_q & arm_up_q & arm_dn_q & new_pulse & ~overlap;
  assign lock_d   = overlap | (lock_q & ~lock_clr);
  assign arm_up_d = lock_d & ~overlap & (arm_up_q | ~up_on);
  assign arm_dn_d = lock_d & ~overlap & (arm_dn_q | ~dn_on);

  assign blk_up_d = hold_in_pulse(sc_up, blk_up_q, up_on);
  assign blk_dn_d = hold_in_pulse(sc_dn, blk_dn_q, dn_on);
  assign warn_d   = ilim | (warn_q & ~new_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_was   <= 1'b0;
      dn_was   <= 1'b0;
      arm_up_q <= 1'b0;
      arm_dn_q <= 1'b0;
      lock_q   <= 1'b0;
      blk_up_q <= 1'b0;
      blk_dn_q <= 1'b0;
      warn_q   <= 1'b0;
      gup_q    <= 1'b0;
      gdn_q    <= 1'b0;
    end else begin
      up_was   <= up_on;
      dn_was   <= dn_on;
      arm_up_q <= arm_up_d;
      arm_dn_q <= arm_dn_d;
      lock_q   <= lock_d;
      blk_up_q <= blk_up_d;
      blk_dn_q <= blk_dn_d;
      warn_q   <= warn_d;
      gup_q    <= up_on & ~lock_d & ~blk_up_d;
      gdn_q    <= dn_on & ~lock_d & ~blk_dn_d;
    end
  end

  assign gate_up = gup_q;
  assign gate_dn = gdn_q;
  assign lock    = lock_q;
  assign blk_up  = blk_up_q;
  assign blk_dn  = blk_dn_q;
  assign warn    = warn_q;

  // R3: never both gates of a leg
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gup_q && gdn_q));
  // R3: a latched leg has both gates off
  a_r3_lock_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (!gup_q && !gdn_q));
  // R4: no new command edge, no release
  a_r4_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !new_pulse) |=> lock_q);
  // R6: a blocked switch stays off
  a_r6_blk_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_up_q |-> !gup_q) and (blk_dn_q |-> !gdn_q));
  // R8: warning held until next pulse
  a_r8_warn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && !new_pulse) |=> warn_q);
  // R2: a gate is only on after its command was on
  a_r2_gate_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (gup_q |-> $past(up_on)) and (gdn_q |-> $past(dn_on)));
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bgc_pkg::*;
#(
  parameter int NPH         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] up_cmd_n,
  input  logic [NPH-1:0] dn_cmd_n,
  input  logic           brk_cmd_n,
  input  logic [NPH-1:0] sc_up,
  input  logic [NPH-1:0] sc_dn,
  input  logic [NPH-1:0] ilim,
  output logic [NPH-1:0] gate_up,
  output logic [NPH-1:0] gate_dn,
  output logic           gate_brk,
  output logic           fault_n,
  output logic           warn_n
);
  localparam int CMD_W  = 2*NPH + 1;
  localparam int FLAG_W = 3*NPH;

  logic [CMD_W-1:0]  cmd_s;
  logic [FLAG_W-1:0] flag_s;
  logic [NPH-1:0]    up_on, dn_on, sc_up_s, sc_dn_s, ilim_s;
  logic              brk_on, brk_q;
  logic [NPH-1:0]    lock, blk_up, blk_dn, warn;

  bgc_sync #(.W(CMD_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cmd_sync (
    .clk(clk), .rst_n(rst_n), .d({brk_cmd_n, dn_cmd_n, up_cmd_n}), .q(cmd_s));

  bgc_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_flag_sync (
    .clk(clk), .rst_n(rst_n), .d({ilim, sc_dn, sc_up}), .q(flag_s));

  assign up_on   = ~cmd_s[NPH-1:0];
  assign dn_on   = ~cmd_s[2*NPH-1:NPH];
  assign brk_on  = ~cmd_s[CMD_W-1];
  assign sc_up_s = flag_s[NPH-1:0];
  assign sc_dn_s = flag_s[2*NPH-1:NPH];
  assign ilim_s  = flag_s[3*NPH-1:2*NPH];

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_leg
      bgc_leg u_leg (
        .clk(clk), .rst_n(rst_n),
        .up_on(up_on[p]), .dn_on(dn_on[p]),
        .sc_up(sc_up_s[p]), .sc_dn(sc_dn_s[p]), .ilim(ilim_s[p]),
        .gate_up(gate_up[p]), .gate_dn(gate_dn[p]),
        .lock(lock[p]), .blk_up(blk_up[p]), .blk_dn(blk_dn[p]),
        .warn(warn[p]));
    end
  endgenerate

  // brake: command only, no short-circuit path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= brk_on;
  end
  assign gate_brk = brk_q;

  assign fault_n = ~(|lock | |blk_up | |blk_dn);
  assign warn_n  = ~(|warn);

  // R7: brake gate mirrors its synchronised command one edge later
  a_r7_brake_follow: assert property (@(posedge clk) disable iff (!rst_n)
    gate_brk == $past(brk_on));
  // R9: any latched leg condition pulls the fault flag low
  a_r9_fault_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|lock) |-> !fault_n);
endmodule

// File: tb/test_bridge_gate_ctrl.sv
module test_bridge_gate_ctrl;
  localparam int NPH = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NPH-1:0] up_cmd_n = '1, dn_cmd_n = '1;
  logic           brk_cmd_n = 1'b1;
  logic [NPH-1:0] sc_up = '0, sc_dn = '0, ilim = '0;
  logic [NPH-1:0] gate_up, gate_dn;
  logic           gate_brk, fault_n, warn_n;

  typedef struct packed {
    logic [NPH-1:0] gu;
    logic [NPH-1:0] gd;
    logic           gb;
    logic           fn;
    logic           wn;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0;
  event  smp;

  always #10 clk = ~clk;

  bridge_gate_ctrl #(.NPH(NPH)) i_bridge_gate_ctrl (
    .clk(clk), .rst_n(rst_n),
    .up_cmd_n(up_cmd_n), .dn_cmd_n(dn_cmd_n), .brk_cmd_n(brk_cmd_n),
    .sc_up(sc_up), .sc_dn(sc_dn), .ilim(ilim),
    .gate_up(gate_up), .gate_dn(gate_dn), .gate_brk(gate_brk),
    .fault_n(fault_n), .warn_n(warn_n));

  // driver: push expectation, let three edges pass, sample at the falling edge
  task automatic step(input string tag, input exp_t e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    repeat (3) @(negedge clk);
    -> smp;
  endtask

  function automatic exp_t mk(input logic [NPH-1:0] gu, input logic [NPH-1:0] gd,
                              input logic gb, input logic fn, input logic wn);
    exp_t e;
    e.gu = gu; e.gd = gd; e.gb = gb; e.fn = fn; e.wn = wn;
    return e;
  endfunction

  // monitor: pop and compare
  initial begin
    forever begin
      @smp;
      if (exp_q.size() > 0) begin
        exp_t  e;
        exp_t  a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = mk(gate_up, gate_dn, gate_brk, fault_n, warn_n);
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got gu=%b gd=%b gb=%b fn=%b wn=%b exp gu=%b gd=%b gb=%b fn=%b wn=%b",
                   t, a.gu, a.gd, a.gb, a.fn, a.wn, e.gu, e.gd, e.gb, e.fn, e.wn);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, sampled while reset is still applied
    step("R1 in reset", mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1));
    rst_n = 1'b1;
    step("R1 after reset", mk(3'b000, 3'b000, 1'b0, 1'b1, 1'b1));

    // R2 normal commands
    up_cmd_n[0] = 1'b0;
    step("R2 upper on", mk(3'b001, 3'b000, 1'b0, 1'b1, 1'b1));
    dn_cmd_n[2] = 1'b0;
    step("R2 lower on", mk(3'b001, 3'b100, 1'b0, 1'b1, 1'b1));
    brk_cmd_n = 1'b0;
    step("R7 brake on", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b1));

    // R3 / R4 interlock on phase 1
    up_cmd_n[1] = 1'b0; dn_cmd_n[1] = 1'b0;
    step("R3 overlap cuts leg, others kept", mk(3'b001, 3'b100, 1'b1, 1'b0, 1'b1));
    up_cmd_n[1] = 1'b1;
    step("R4 one input released", mk(3'b001, 3'b100, 1'b1, 1'b0, 1'b1));
    up_cmd_n[1] = 1'b0;
    step("R4 new overlap keeps latch", mk(3'b001, 3'b100, 1'b1, 1'b0, 1'b1));
    up_cmd_n[1] = 1'b1; dn_cmd_n[1] = 1'b1;
    step("R4 both high without edge", mk(3'b001, 3'b100, 1'b1, 1'b0, 1'b1));
    dn_cmd_n[1] = 1'b0;
    step("R4 release on falling edge", mk(3'b001, 3'b110, 1'b1, 1'b1, 1'b1));
    dn_cmd_n[1] = 1'b1;
    step("R2 lower off", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b1));

    // R5 / R6 short circuit on lower switch of phase 2
    sc_dn[2] = 1'b1;
    step("R5 only that switch off, R7 brake kept", mk(3'b001, 3'b000, 1'b1, 1'b0, 1'b1));
    sc_dn[2] = 1'b0;
    step("R6 block held within pulse", mk(3'b001, 3'b000, 1'b1, 1'b0, 1'b1));
    dn_cmd_n[2] = 1'b1;
    step("R6 pulse end clears fault", mk(3'b001, 3'b000, 1'b1, 1'b1, 1'b1));
    dn_cmd_n[2] = 1'b0;
    step("R6 next pulse switches on", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b1));
    sc_up[0] = 1'b1;
    step("R5 upper switch isolated", mk(3'b000, 3'b100, 1'b1, 1'b0, 1'b1));
    sc_up[0] = 1'b0; up_cmd_n[0] = 1'b1;
    step("R6 flag and command drop together", mk(3'b000, 3'b100, 1'b1, 1'b1, 1'b1));

    // R8 warning on phase 0
    up_cmd_n[0] = 1'b0;
    step("R2 upper on again", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b1));
    ilim[0] = 1'b1;
    step("R8 warning raised", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b0));
    ilim[0] = 1'b0;
    step("R8 held after flag clears", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b0));
    up_cmd_n[0] = 1'b1;
    step("R8 held through command end", mk(3'b000, 3'b100, 1'b1, 1'b1, 1'b0));
    up_cmd_n[0] = 1'b0;
    step("R8 reset by next pulse", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b1));

    // R9 conditions from other phases, switches off
    ilim[2] = 1'b1; sc_up[1] = 1'b1;
    step("R9 any phase reports", mk(3'b001, 3'b100, 1'b1, 1'b0, 1'b0));
    ilim[2] = 1'b0; sc_up[1] = 1'b0;
    step("R9 fault gone, warn kept", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b0));
    dn_cmd_n[2] = 1'b1;
    step("R8 rising edge does not reset", mk(3'b001, 3'b000, 1'b1, 1'b1, 1'b0));
    dn_cmd_n[2] = 1'b0;
    step("R8 lower falling edge resets", mk(3'b001, 3'b100, 1'b1, 1'b1, 1'b1));
    brk_cmd_n = 1'b1;
    step("R7 brake off", mk(3'b001, 3'b100, 1'b0, 1'b1, 1'b1));

    @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending exp 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule